// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank with Wakeup

This block is a bank of 32 general-purpose I/O lines behind a 32-bit register interface. Every line has a direction bit, an output data bit and a synchronised input sample. On input lines the bank watches for rising edges, falling edges, high levels and low levels. Each detected event is posted at once into two independent status registers. Each status register has its own enable mask and drives its own interrupt output, so two consumers can take interrupts from the same lines.

Software clears status bits by writing ones. A level condition that is still active re-asserts straight after the clear. It also re-asserts after the direction or level-detect settings change. The output data, both interrupt enables and the wakeup enable each have a set alias and a clear alias, so single bits can be changed without a read-modify-write. When wakeup is armed in the config register, an idle mode is selected and the line is wake-enabled, an event also produces a one-cycle wakeup request. The debounce enable and debounce time registers only store their values.

Register access is a single-cycle write strobe with a byte address. Read data is combinational from the address. Reads of an alias return the register behind it, and reads of unmapped offsets return zero.

Top module: `gpio_dual_irq_bank`

## Requirements
- R1: After reset the direction register reads all ones (1 = input, 0 = driven output). Control (0x30) reads 2, revision (0x00) reads 0x18, system status (0x14) reads 1, and config, both status registers, both enables, wake enable, data-out, the detect registers and the debounce registers read 0. Both interrupt outputs are low.
- R2: When a synchronised input goes from 0 to 1 on a line whose direction bit is 1, an event fires if the line's bit is set in rise-detect (0x48) or in high-detect (0x44).
- R3: When a synchronised input goes from 1 to 0 on an input line, an event fires if the line's bit is set in fall-detect (0x4C) or in low-detect (0x40). An input moving the other way fires nothing from these settings.
- R4: An event sets the line's bit in status A (0x18) and in status B (0x28) on the same clock. irq_a is high while status A AND enable A (0x1C) is nonzero, and irq_b is high while status B AND enable B (0x2C) is nonzero.
- R5: Writing ones to a status register clears those bits. If any set bit was cleared, that register then gains dir AND ((din AND high-detect) OR (NOT din AND low-detect)), so a still-active level stays set.
- R6: A write to direction (0x34), low-detect or high-detect re-evaluates that level term into both status registers on the next clock.
- R7: Clear/set aliases sit at 0x60/0x64 (enable A), 0x70/0x74 (enable B), 0x80/0x84 (wake enable) and 0x90/0x94 (data-out). Clear removes the written ones, set adds them, and reading an alias returns the underlying register.
- R8: A config (0x10) write with bit 1 set soft-resets direction, detect, enable, status, wake-enable, debounce and control registers to their R1 values. Data-out is kept. Config stores the written value AND 0x1D. Control keeps only bits 2:0.
- R9: wake_req pulses for one clock together with an event only when config bit 2 is 1, config bits 4:3 are nonzero, and the event's line is set in wake enable (0x20).
- R10: pin_out is data-out AND NOT direction, and pin_oe is NOT direction. A line switched to output drives its stored data-out on the clock after the direction write.
- R11: Lines whose direction bit is 0 never post events or level status, whatever their input does.
- R12: Writes to revision, system status and data-in (0x38) change nothing. Data-in reads the synchronised input, and reads of unmapped offsets return 0.
- R13: Debounce enable (0x50) stores 32 bits and debounce time (0x54) stores 8 bits. Neither affects detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pin_in | input | 32 | Asynchronous line inputs |
| pin_out | output | 32 | Output data on driven lines |
| pin_oe | output | 32 | Output enable per line |
| irq_a | output | 1 | Interrupt from status A and enable A |
| irq_b | output | 1 | Interrupt from status B and enable B |
| wake_req | output | 1 | One-cycle wakeup request |

## Verification
A wrong synchroniser or edge memory shows as a status bit that appears too early, too late or twice, three clocks after a pin change. A status register that missed a posting or an alias that corrupted an enable shows at once on irq_a or irq_b, and on the status read that follows. A level term evaluated with stale direction or detect values shows one clock after the configuring write, as a status bit that should have re-asserted but did not, or the reverse. Errors in the direction or data-out state show on pin_out and pin_oe in the same cycle the register changes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned GB_LINES = 32;
  localparam int unsigned GB_AW    = 8;

  localparam logic [7:0] OFS_REV     = 8'h00;
  localparam logic [7:0] OFS_CFG     = 8'h10;
  localparam logic [7:0] OFS_SSTAT   = 8'h14;
  localparam logic [7:0] OFS_ST_A    = 8'h18;
  localparam logic [7:0] OFS_EN_A    = 8'h1C;
  localparam logic [7:0] OFS_WAKE    = 8'h20;
  localparam logic [7:0] OFS_ST_B    = 8'h28;
  localparam logic [7:0] OFS_EN_B    = 8'h2C;
  localparam logic [7:0] OFS_CTRL    = 8'h30;
  localparam logic [7:0] OFS_DIR     = 8'h34;
  localparam logic [7:0] OFS_DIN     = 8'h38;
  localparam logic [7:0] OFS_DOUT    = 8'h3C;
  localparam logic [7:0] OFS_LOW     = 8'h40;
  localparam logic [7:0] OFS_HIGH    = 8'h44;
  localparam logic [7:0] OFS_RISE    = 8'h48;
  localparam logic [7:0] OFS_FALL    = 8'h4C;
  localparam logic [7:0] OFS_DB_EN   = 8'h50;
  localparam logic [7:0] OFS_DB_TIME = 8'h54;
  localparam logic [7:0] OFS_ENA_CLR = 8'h60;
  localparam logic [7:0] OFS_ENA_SET = 8'h64;
  localparam logic [7:0] OFS_ENB_CLR = 8'h70;
  localparam logic [7:0] OFS_ENB_SET = 8'h74;
  localparam logic [7:0] OFS_WK_CLR  = 8'h80;
  localparam logic [7:0] OFS_WK_SET  = 8'h84;
  localparam logic [7:0] OFS_DO_CLR  = 8'h90;
  localparam logic [7:0] OFS_DO_SET  = 8'h94;

  localparam int unsigned CFG_W   = 5;
  localparam int unsigned CTRL_W  = 3;
  localparam int unsigned DBT_W   = 8;
  localparam logic [CFG_W-1:0]  CFG_KEEP = 5'h1D;
  localparam logic [CTRL_W-1:0] CTRL_RST = 3'd2;
  localparam int unsigned REV_VALUE   = 32'h18;
  localparam int unsigned SSTAT_VALUE = 32'h1;

  typedef enum logic [1:0] {
    MASK_HOLD,
    MASK_LOAD,
    MASK_SET,
    MASK_CLR
  } mask_op_e;
endpackage

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter bit          HONOR_SOFT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  mask_op_e     op,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (HONOR_SOFT && soft_rst) d = '0;
    case (op)
      MASK_LOAD: d = data;
      MASK_SET:  d = q | data;
      MASK_CLR:  d = q & ~data;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  AST_SET_ALIAS_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MASK_SET) |=> ((q & $past(data)) == $past(data))) // R7
    else $error("set alias lost bits");
  AST_CLR_ALIAS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == MASK_CLR) |=> ((q & $past(data)) == '0)) // R7
    else $error("clear alias kept bits");
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] din_o,
  output logic [W-1:0] prev_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] chain_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= pin_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[k] <= '0;
      else        chain_q[k] <= chain_q[k-1];
    end
  end

  assign din_o  = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/gpio_evt_logic.sv
module gpio_evt_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] din,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] low_en,
  input  logic [W-1:0] high_en,
  output logic [W-1:0] evt,
  output logic [W-1:0] lvl
);
  logic [W-1:0] went_up;
  logic [W-1:0] went_down;

  always_comb begin
    went_up   = din & ~prev;
    went_down = ~din & prev;
    evt = dir & ((went_up & (rise_en | high_en)) | (went_down & (fall_en | low_en)));
    lvl = dir & ((din & high_en) | (~din & low_en));
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] lvl,
  input  logic         reeval,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  mask_op_e     en_op,
  input  logic [W-1:0] en_data,
  output logic [W-1:0] status_q,
  output logic [W-1:0] enable_q,
  output logic         irq
);
  logic [W-1:0] status_d;
  logic         clr_hit;

  gpio_mask_reg #(.W(W), .HONOR_SOFT(1'b1)) u_enable (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .op       (en_op),
    .data     (en_data),
    .q        (enable_q)
  );

  always_comb begin
    clr_hit  = clr_we && ((status_q & clr_data) != '0);
    status_d = status_q;
    if (clr_hit) status_d = status_q & ~clr_data;
    if (clr_hit || reeval) status_d = status_d | lvl;
    status_d = status_d | evt;
    if (soft_rst) status_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign irq = (status_q & enable_q) != '0;

  AST_EVT_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt != '0) && !soft_rst) |=> ((status_q & $past(evt)) == $past(evt))) // R4
    else $error("event not posted");
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt == '0) && !reeval && !clr_we) |=> ((status_q & ~$past(status_q)) == '0)) // R5
    else $error("status bit appeared without cause");
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  din,
  input  logic [W-1:0]  evt,
  input  logic [W-1:0]  st_a,
  input  logic [W-1:0]  st_b,
  input  logic [W-1:0]  en_a,
  input  logic [W-1:0]  en_b,
  output logic          soft_rst,
  output logic          clr_a_we,
  output logic          clr_b_we,
  output mask_op_e      en_a_op,
  output mask_op_e      en_b_op,
  output logic          reeval_q,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  dout_q,
  output logic [W-1:0]  rise_q,
  output logic [W-1:0]  fall_q,
  output logic [W-1:0]  low_q,
  output logic [W-1:0]  high_q,
  output logic          wake_req
);
  logic [CFG_W-1:0]  cfg_q,  cfg_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DBT_W-1:0]  dbt_q,  dbt_d;
  logic [W-1:0] dir_d, rise_d, fall_d, low_d, high_d, dben_q, dben_d;
  logic [W-1:0] wake_en_q;
  logic         reeval_d, wake_d, wake_q;
  mask_op_e     wk_op, do_op;

  function automatic mask_op_e pick_op(input logic w, input logic [AW-1:0] a,
                                       input logic [AW-1:0] base,
                                       input logic [AW-1:0] clr,
                                       input logic [AW-1:0] set);
    if (!w)            return MASK_HOLD;
    else if (a == base) return MASK_LOAD;
    else if (a == clr)  return MASK_CLR;
    else if (a == set)  return MASK_SET;
    else                return MASK_HOLD;
  endfunction

  always_comb begin
    soft_rst = we && (addr == OFS_CFG) && wdata[1];
    clr_a_we = we && (addr == OFS_ST_A);
    clr_b_we = we && (addr == OFS_ST_B);
    en_a_op  = pick_op(we, addr, OFS_EN_A, OFS_ENA_CLR, OFS_ENA_SET);
    en_b_op  = pick_op(we, addr, OFS_EN_B, OFS_ENB_CLR, OFS_ENB_SET);
    wk_op    = pick_op(we, addr, OFS_WAKE, OFS_WK_CLR,  OFS_WK_SET);
    do_op    = pick_op(we, addr, OFS_DOUT, OFS_DO_CLR,  OFS_DO_SET);
  end

  gpio_mask_reg #(.W(W), .HONOR_SOFT(1'b1)) u_wake_en (
    .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
    .op (wk_op), .data (wdata), .q (wake_en_q)
  );

  gpio_mask_reg #(.W(W), .HONOR_SOFT(1'b0)) u_dout (
    .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
    .op (do_op), .data (wdata), .q (dout_q)
  );

  always_comb begin
    cfg_d  = cfg_q;
    ctrl_d = ctrl_q;
    dir_d  = dir_q;
    rise_d = rise_q;
    fall_d = fall_q;
    low_d  = low_q;
    high_d = high_q;
    dben_d = dben_q;
    dbt_d  = dbt_q;
    if (soft_rst) begin
      ctrl_d = CTRL_RST;
      dir_d  = '1;
      rise_d = '0;
      fall_d = '0;
      low_d  = '0;
      high_d = '0;
      dben_d = '0;
      dbt_d  = '0;
    end
    if (we) begin
      case (addr)
        OFS_CFG:     cfg_d  = wdata[CFG_W-1:0] & CFG_KEEP;
        OFS_CTRL:    ctrl_d = wdata[CTRL_W-1:0];
        OFS_DIR:     dir_d  = wdata;
        OFS_RISE:    rise_d = wdata;
        OFS_FALL:    fall_d = wdata;
        OFS_LOW:     low_d  = wdata;
        OFS_HIGH:    high_d = wdata;
        OFS_DB_EN:   dben_d = wdata;
        OFS_DB_TIME: dbt_d  = wdata[DBT_W-1:0];
        default:     ;
      endcase
    end
    reeval_d = we && ((addr == OFS_DIR) || (addr == OFS_LOW) || (addr == OFS_HIGH));
    wake_d   = cfg_q[2] && (cfg_q[4:3] != 2'b00) && ((evt & wake_en_q) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      ctrl_q   <= CTRL_RST;
      dir_q    <= '1;
      rise_q   <= '0;
      fall_q   <= '0;
      low_q    <= '0;
      high_q   <= '0;
      dben_q   <= '0;
      dbt_q    <= '0;
      reeval_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      ctrl_q   <= ctrl_d;
      dir_q    <= dir_d;
      rise_q   <= rise_d;
      fall_q   <= fall_d;
      low_q    <= low_d;
      high_q   <= high_d;
      dben_q   <= dben_d;
      dbt_q    <= dbt_d;
      reeval_q <= reeval_d;
      wake_q   <= wake_d;
    end
  end

  assign wake_req = wake_q;

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_REV:     rdata = W'(REV_VALUE);
      OFS_CFG:     rdata = W'(cfg_q);
      OFS_SSTAT:   rdata = W'(SSTAT_VALUE);
      OFS_ST_A:    rdata = st_a;
      OFS_ST_B:    rdata = st_b;
      OFS_EN_A, OFS_ENA_CLR, OFS_ENA_SET: rdata = en_a;
      OFS_EN_B, OFS_ENB_CLR, OFS_ENB_SET: rdata = en_b;
      OFS_WAKE, OFS_WK_CLR, OFS_WK_SET:   rdata = wake_en_q;
      OFS_DOUT, OFS_DO_CLR, OFS_DO_SET:   rdata = dout_q;
      OFS_CTRL:    rdata = W'(ctrl_q);
      OFS_DIR:     rdata = dir_q;
      OFS_DIN:     rdata = din;
      OFS_LOW:     rdata = low_q;
      OFS_HIGH:    rdata = high_q;
      OFS_RISE:    rdata = rise_q;
      OFS_FALL:    rdata = fall_q;
      OFS_DB_EN:   rdata = dben_q;
      OFS_DB_TIME: rdata = W'(dbt_q);
      default:     rdata = '0;
    endcase
  end

  AST_SOFT_RST_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (dir_q == '1)) // R8
    else $error("soft reset left outputs");
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($past(cfg_q[2]) && ($past(cfg_q[4:3]) != 2'b00))) // R9
    else $error("wake without arming");
endmodule

// File: rtl/gpio_dual_irq_bank.sv
module gpio_dual_irq_bank
  import gpio_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [GB_AW-1:0]    reg_addr,
  input  logic [GB_LINES-1:0] reg_wdata,
  output logic [GB_LINES-1:0] reg_rdata,
  input  logic [GB_LINES-1:0] pin_in,
  output logic [GB_LINES-1:0] pin_out,
  output logic [GB_LINES-1:0] pin_oe,
  output logic                irq_a,
  output logic                irq_b,
  output logic                wake_req
);
  localparam int unsigned W       = GB_LINES;
  localparam int unsigned N_UNITS = 2;

  logic [W-1:0] din, prev, evt, lvl;
  logic [W-1:0] dir_q, dout_q, rise_q, fall_q, low_q, high_q;
  logic         soft_rst, reeval_q;
  logic         clr_we   [N_UNITS];
  mask_op_e     en_op    [N_UNITS];
  logic [W-1:0] st       [N_UNITS];
  logic [W-1:0] en       [N_UNITS];
  logic         irq_vec  [N_UNITS];

  gpio_in_sync #(.W(W), .STAGES(2)) u_sync (
    .clk (clk), .rst_n (rst_n), .pin_i (pin_in), .din_o (din), .prev_o (prev)
  );

  gpio_evt_logic #(.W(W)) u_evt (
    .dir (dir_q), .din (din), .prev (prev),
    .rise_en (rise_q), .fall_en (fall_q), .low_en (low_q), .high_en (high_q),
    .evt (evt), .lvl (lvl)
  );

  gpio_bank_regs #(.W(W), .AW(GB_AW)) u_regs (
    .clk (clk), .rst_n (rst_n),
    .we (reg_we), .addr (reg_addr), .wdata (reg_wdata), .rdata (reg_rdata),
    .din (din), .evt (evt),
    .st_a (st[0]), .st_b (st[1]), .en_a (en[0]), .en_b (en[1]),
    .soft_rst (soft_rst), .clr_a_we (clr_we[0]), .clr_b_we (clr_we[1]),
    .en_a_op (en_op[0]), .en_b_op (en_op[1]), .reeval_q (reeval_q),
    .dir_q (dir_q), .dout_q (dout_q),
    .rise_q (rise_q), .fall_q (fall_q), .low_q (low_q), .high_q (high_q),
    .wake_req (wake_req)
  );

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    gpio_irq_unit #(.W(W)) u_irq (
      .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
      .evt (evt), .lvl (lvl), .reeval (reeval_q),
      .clr_we (clr_we[u]), .clr_data (reg_wdata),
      .en_op (en_op[u]), .en_data (reg_wdata),
      .status_q (st[u]), .enable_q (en[u]), .irq (irq_vec[u])
    );
  end

  assign irq_a   = irq_vec[0];
  assign irq_b   = irq_vec[1];
  assign pin_oe  = ~dir_q;
  assign pin_out = dout_q & ~dir_q;

  AST_INPUT_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0)) // R10
    else $error("input line driven");
  AST_OUTPUT_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & pin_oe) == '0) |=> ((st[0] & ~$past(st[0]) & $past(pin_oe) & ~$past(reeval_q ? lvl : '0)) == '0)) // R11
    else $error("output line posted status");
endmodule

// File: tb/tb_gpio_dual_irq_bank.sv
module tb_gpio_dual_irq_bank;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  rd_addr;
  logic [31:0] wr_data;
  logic [31:0] rdata;
  logic [31:0] pins;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq_a, irq_b, wake_req;
  logic [7:0]  bus_addr;
  int          checks;
  int          errors;
  int          wake_cnt;
  bit          done;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] e;
    string       tag;
  } rd_item_t;
  rd_item_t sbq[$];

  assign bus_addr = wr_en ? wr_addr : rd_addr;

  gpio_dual_irq_bank dut (
    .clk (clk), .rst_n (rst_n), .reg_we (wr_en), .reg_addr (bus_addr),
    .reg_wdata (wr_data), .reg_rdata (rdata), .pin_in (pins),
    .pin_out (pin_out), .pin_oe (pin_oe),
    .irq_a (irq_a), .irq_b (irq_b), .wake_req (wake_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && wake_req) wake_cnt++;

  // monitor: pops expected reads and compares against the bus
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        rd_addr = sbq[0].a;
        #1;
        checks++;
        if (rdata !== sbq[0].e) begin
          errors++;
          $display("FAIL %s addr %h actual %h expected %h", sbq[0].tag, sbq[0].a, rdata, sbq[0].e);
        end
        void'(sbq.pop_front());
      end
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    it.a = a; it.e = e; it.tag = tag;
    sbq.push_back(it);
    while (sbq.size() != 0) @(posedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pin(input int idx, input logic v);
    @(negedge clk);
    pins[idx] = v;
    settle(5);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; wake_cnt = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; rd_addr = 8'hFC; wr_data = '0; pins = '0;
    settle(3);
    @(negedge clk) rst_n = 1'b1;
    settle(2);

    // R1 reset state
    expect_rd(8'h00, 32'h18, "R1 revision");
    expect_rd(8'h14, 32'h1, "R1 system status");
    expect_rd(8'h34, 32'hFFFF_FFFF, "R1 direction");
    expect_rd(8'h30, 32'h2, "R1 control");
    expect_rd(8'h10, 32'h0, "R1 config");
    expect_rd(8'h18, 32'h0, "R1 status A");
    chk("R1 irq_a", {31'b0, irq_a}, 32'h0);
    chk("R1 irq_b", {31'b0, irq_b}, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);

    // R7 aliases
    wr(8'h64, 32'hF0);
    expect_rd(8'h1C, 32'hF0, "R7 enable A set alias");
    wr(8'h60, 32'h30);
    expect_rd(8'h60, 32'hC0, "R7 enable A clear alias readback");
    wr(8'h1C, 32'h1);
    expect_rd(8'h64, 32'h1, "R7 enable A load");
    wr(8'h2C, 32'h2);
    wr(8'h74, 32'h0);
    expect_rd(8'h70, 32'h2, "R7 enable B alias");
    wr(8'h84, 32'h5);
    wr(8'h80, 32'h1);
    expect_rd(8'h20, 32'h4, "R7 wake enable aliases");

    // R2 rising event on line 0, R4 dual posting
    wr(8'h48, 32'h1);
    drive_pin(0, 1'b1);
    expect_rd(8'h18, 32'h1, "R2 status A after rise");
    expect_rd(8'h28, 32'h1, "R4 status B after rise");
    chk("R4 irq_a", {31'b0, irq_a}, 32'h1);
    chk("R4 irq_b masked", {31'b0, irq_b}, 32'h0);

    // R3 falling event on line 1
    wr(8'h4C, 32'h2);
    drive_pin(1, 1'b1);
    expect_rd(8'h18, 32'h1, "R3 rise ignored by fall detect");
    drive_pin(1, 1'b0);
    expect_rd(8'h28, 32'h3, "R3 status B after fall");
    chk("R4 irq_b", {31'b0, irq_b}, 32'h1);

    // R5 write-one-to-clear, R6 level re-evaluation
    wr(8'h18, 32'h1);
    settle(1);
    expect_rd(8'h18, 32'h2, "R5 clear bit 0");
    expect_rd(8'h28, 32'h3, "R5 status B untouched");
    chk("R5 irq_a after clear", {31'b0, irq_a}, 32'h0);
    wr(8'h44, 32'h1);
    settle(1);
    expect_rd(8'h18, 32'h3, "R6 high level re-asserts");
    chk("R6 irq_a", {31'b0, irq_a}, 32'h1);
    wr(8'h18, 32'h1);
    settle(1);
    expect_rd(8'h18, 32'h3, "R5 active level survives clear");
    wr(8'h44, 32'h0);
    wr(8'h18, 32'h3);
    wr(8'h28, 32'h3);
    settle(1);
    expect_rd(8'h18, 32'h0, "R5 status A cleared");
    expect_rd(8'h28, 32'h0, "R5 status B cleared");

    // R11 output lines post nothing; R10 pin gating
    wr(8'h34, 32'hFFFF_FFFB);
    wr(8'h44, 32'h4);
    drive_pin(2, 1'b1);
    settle(1);
    expect_rd(8'h18, 32'h0, "R11 output line no status");
    wr(8'h94, 32'h4);
    chk("R10 pin_out driven", pin_out, 32'h4);
    chk("R10 pin_oe", pin_oe, 32'h4);
    wr(8'h94, 32'h8);
    chk("R10 input line not driven", pin_out, 32'h4);
    expect_rd(8'h3C, 32'hC, "R10 data-out");
    wr(8'h34, 32'hFFFF_FFF3);
    chk("R10 switch to output drives", pin_out, 32'hC);
    wr(8'h34, 32'hFFFF_FFFF);
    chk("R10 back to input", pin_out, 32'h0);
    settle(1);
    expect_rd(8'h18, 32'h4, "R6 direction write re-evaluates A");
    expect_rd(8'h28, 32'h4, "R6 direction write re-evaluates B");
    wr(8'h90, 32'hC);
    expect_rd(8'h3C, 32'h0, "R7 data-out clear alias");

    // R9 wakeup
    wr(8'h10, 32'h04);
    wr(8'h48, 32'h10);
    drive_pin(4, 1'b1);
    chk("R9 no wake with idle mode 0", wake_cnt, 0);
    expect_rd(8'h18, 32'h14, "R2 line 4 rise");
    wr(8'h10, 32'h0C);
    wr(8'h84, 32'h10);
    drive_pin(4, 1'b0);
    drive_pin(4, 1'b1);
    chk("R9 wake pulse", wake_cnt, 1);

    // R8 soft reset and field masks
    wr(8'h10, 32'hFF);
    settle(1);
    expect_rd(8'h10, 32'h1D, "R8 config masked");
    expect_rd(8'h34, 32'hFFFF_FFFF, "R8 direction reset");
    expect_rd(8'h1C, 32'h0, "R8 enable A reset");
    expect_rd(8'h18, 32'h0, "R8 status A reset");
    expect_rd(8'h48, 32'h0, "R8 rise detect reset");
    chk("R8 irq_a", {31'b0, irq_a}, 32'h0);
    wr(8'h30, 32'hFF);
    expect_rd(8'h30, 32'h7, "R8 control width");

    // R12 read-only and unmapped; R13 debounce storage
    wr(8'h00, 32'h55);
    wr(8'h38, 32'hFFFF);
    expect_rd(8'h00, 32'h18, "R12 revision read-only");
    expect_rd(8'h38, 32'h15, "R12 data-in");
    expect_rd(8'h58, 32'h0, "R12 unmapped");
    expect_rd(8'hFC, 32'h0, "R12 unmapped top");
    wr(8'h50, 32'hA5A5_A5A5);
    wr(8'h54, 32'h1FF);
    expect_rd(8'h50, 32'hA5A5_A5A5, "R13 debounce enable");
    expect_rd(8'h54, 32'hFF, "R13 debounce time");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule